// File: doc/BRIEF.md
# Receive FIFO Acceptance Filter

This block decides whether a received CAN frame is accepted by the receive FIFO and, if so, by which acceptance filter. One filter table of 32-bit words is read in one of three layouts: one full extended-identifier filter per word, two standard-identifier filters per word, or four partial 8-bit filters per word. The same table therefore holds `NUM_WORDS`, `2*NUM_WORDS` or `4*NUM_WORDS` filters. Each word is masked either by its own mask word (the first `NUM_IND_MASK` words) or by one shared global mask.

A search starts on `start_i`. The identifier, frame flags, layout select, precedence select and the mailbox-match flag from the mailbox matcher are captured at that point. Eight filters are compared per clock, from the lowest index upward. The search stops at the first chunk that contains a hit, or at the last chunk. It then pulses `done_o` and presents three results: whether a filter matched, the lowest matching filter index, and the destination of the frame (FIFO or mailbox). When both the FIFO filter and the mailbox match, the precedence select decides which one receives the frame.

Top module: `acf_filter`

## Requirements
- R1: With `fmt_i`=0 each word w is filter w and is compared against the key {rtr, ide, 1'b0, id29}. Bit 31 holds RTR, bit 30 holds IDE and bit 29 is compared against 0. An extended ID sits in bits 28:0. A standard ID sits in bits 28:18, with bits 17:0 compared against 0.
- R2: With `fmt_i`=1 word w holds two filters: filter 2w in bits 15:0 and filter 2w+1 in bits 31:16. Each 16-bit filter has RTR in bit 15 and IDE in bit 14. Bits 13:3 hold the standard ID, or ID bits 28:18 of an extended frame. Bits 2:0 are compared against 0.
- R3: With `fmt_i`=2 or 3 word w holds four filters. Filter 4w+k occupies bits 8k+7:8k and is compared with standard ID bits 10:3, or extended ID bits 28:21. RTR and IDE take no part in the comparison.
- R4: A mask bit of 1 requires the filter bit to equal the key bit, and a mask bit of 0 makes that bit don't-care. Words 0 to `NUM_IND_MASK`-1 use their own word of `ind_mask_i`, and all other words use `glob_mask_i`. The mask word is sliced in the same way as the filter word.
- R5: When several filters match, `hit_idx_o` reports the lowest matching filter index.
- R6: A search compares filters 8c to 8c+7 in its c-th cycle. `done_o` is high for exactly one cycle, c+1 cycles after the clock edge that accepts `start_i`. Here c is the chunk holding the first hit, or else the last chunk. A search with no hit therefore takes `NUM_WORDS`/8, /4 or /2 cycles for layouts 0, 1 and 2.
- R7: `busy_o` is high from the accepting edge until `done_o`. A `start_i` seen while `busy_o` is high is ignored.
- R8: On `done_o` the frame goes to the FIFO (`to_fifo_o`) if a filter matched and either `fifo_first_i`=1 or `mb_hit_i`=0. It goes to the mailbox (`to_mb_o`) if `mb_hit_i`=1 and either `fifo_first_i`=0 or no filter matched. `fifo_hit_o` reports a filter match even when the mailbox wins.
- R9: After reset `busy_o`, `done_o`, `fifo_hit_o`, `to_fifo_o` and `to_mb_o` are 0, and `hit_idx_o` is 0.
- R10: A search with no filter match gives `fifo_hit_o`=0 and `hit_idx_o`=0.
- R11: The identifier, flags, layout select, precedence select and mailbox flag are taken only on the accepting edge. Changing them during a search does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (taken when not busy) |
| id_i | input | 29 | Received identifier; standard ID in bits 10:0 |
| ide_i | input | 1 | 1 = extended 29-bit identifier |
| rtr_i | input | 1 | Remote frame flag |
| fmt_i | input | 2 | Table layout: 0 extended, 1 standard, 2/3 partial |
| fifo_first_i | input | 1 | 1 = FIFO wins over a matching mailbox |
| mb_hit_i | input | 1 | A mailbox matched this frame |
| filt_tab_i | input | NUM_WORDS*32 | Filter table, word w in bits 32w+31:32w |
| ind_mask_i | input | NUM_IND_MASK*32 | Individual masks, one word per filter word |
| glob_mask_i | input | 32 | Shared mask for the remaining words |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion strobe |
| fifo_hit_o | output | 1 | A FIFO filter matched |
| hit_idx_o | output | $clog2(NUM_WORDS*4) | Lowest matching filter index |
| to_fifo_o | output | 1 | Frame routed to the FIFO |
| to_mb_o | output | 1 | Frame routed to the mailbox |

## Verification
The bench builds the block with `NUM_WORDS`=16 and `NUM_IND_MASK`=4. A search then lasts at most 2, 4 or 8 cycles in the three layouts, so every exact latency, including the last chunk, is checked by counting cycles. Words 4 to 15 fall under the global mask, which lets one scenario show an individual mask and the global mask acting on the same entry moved between words. Filters in the upper half and upper bytes of words in later chunks exercise the index arithmetic of every layout.

// File: rtl/acf_pkg.sv
package acf_pkg;

  localparam int unsigned LANES = 8;

  typedef enum logic [1:0] {
    FMT_EXT   = 2'd0,
    FMT_STD   = 2'd1,
    FMT_PART  = 2'd2,
    FMT_PART2 = 2'd3
  } acf_fmt_e;

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
  } acf_frame_t;

  function automatic logic [31:0] key_ext(acf_frame_t f);
    return {f.rtr, f.ide, 1'b0, (f.ide ? f.id : {f.id[10:0], 18'b0})};
  endfunction

  function automatic logic [15:0] key_std(acf_frame_t f);
    return {f.rtr, f.ide, (f.ide ? f.id[28:18] : f.id[10:0]), 3'b0};
  endfunction

  function automatic logic [7:0] key_part(acf_frame_t f);
    return f.ide ? f.id[28:21] : f.id[10:3];
  endfunction

endpackage

// File: rtl/acf_lane_cmp.sv
module acf_lane_cmp
  import acf_pkg::*;
(
  input  acf_fmt_e    fmt_i,
  input  logic [31:0] word_i,
  input  logic [31:0] mask_i,
  input  logic [1:0]  slot_i,
  input  logic [31:0] k_ext_i,
  input  logic [15:0] k_std_i,
  input  logic [7:0]  k_part_i,
  output logic        hit_o
);

  logic [15:0] ent_h, msk_h;
  logic [7:0]  ent_b, msk_b;

  always_comb begin
    ent_h = slot_i[0] ? word_i[31:16] : word_i[15:0];
    msk_h = slot_i[0] ? mask_i[31:16] : mask_i[15:0];
    case (slot_i)
      2'd0:    begin ent_b = word_i[7:0];   msk_b = mask_i[7:0];   end
      2'd1:    begin ent_b = word_i[15:8];  msk_b = mask_i[15:8];  end
      2'd2:    begin ent_b = word_i[23:16]; msk_b = mask_i[23:16]; end
      default: begin ent_b = word_i[31:24]; msk_b = mask_i[31:24]; end
    endcase
  end

  always_comb begin
    case (fmt_i)
      FMT_EXT: hit_o = ((word_i ^ k_ext_i) & mask_i) == 32'd0;
      FMT_STD: hit_o = ((ent_h ^ k_std_i) & msk_h) == 16'd0;
      default: hit_o = ((ent_b ^ k_part_i) & msk_b) == 8'd0;
    endcase
  end

endmodule

// File: rtl/acf_chunk.sv
module acf_chunk
  import acf_pkg::*;
#(
  parameter int unsigned NUM_WORDS    = 128,
  parameter int unsigned NUM_IND_MASK = 32,
  parameter int unsigned CNT_W        = 6
) (
  input  logic [NUM_WORDS*32-1:0]    tab_i,
  input  logic [NUM_IND_MASK*32-1:0] ind_mask_i,
  input  logic [31:0]                glob_mask_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  acf_fmt_e                   fmt_i,
  input  acf_frame_t                 frm_i,
  output logic [LANES-1:0]           hits_o
);

  localparam int unsigned WORD_W = $clog2(NUM_WORDS);

  logic [31:0] tab_w [NUM_WORDS];
  logic [31:0] k_ext;
  logic [15:0] k_std;
  logic [7:0]  k_part;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_unpack
    assign tab_w[w] = tab_i[w*32 +: 32];
  end

  assign k_ext  = key_ext(frm_i);
  assign k_std  = key_std(frm_i);
  assign k_part = key_part(frm_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [31:0] word, mask;
    logic [1:0]  slot;

    always_comb begin
      int unsigned widx;
      case (fmt_i)
        FMT_EXT: begin widx = 32'(cnt_i) * 8 + l;     slot = 2'd0;       end
        FMT_STD: begin widx = 32'(cnt_i) * 4 + l / 2; slot = 2'(l % 2);  end
        default: begin widx = 32'(cnt_i) * 2 + l / 4; slot = 2'(l % 4);  end
      endcase
      widx = widx % NUM_WORDS;
      word = tab_w[WORD_W'(widx)];
      mask = glob_mask_i;
      for (int unsigned m = 0; m < NUM_IND_MASK; m++)
        if (widx == m) mask = ind_mask_i[m*32 +: 32];
    end

    acf_lane_cmp u_cmp (
      .fmt_i   (fmt_i),
      .word_i  (word),
      .mask_i  (mask),
      .slot_i  (slot),
      .k_ext_i (k_ext),
      .k_std_i (k_std),
      .k_part_i(k_part),
      .hit_o   (hits_o[l])
    );
  end

endmodule

// File: rtl/acf_prio8.sv
module acf_prio8
  import acf_pkg::*;
(
  input  logic [LANES-1:0]         hits_i,
  output logic                     any_o,
  output logic [$clog2(LANES)-1:0] idx_o
);

  assign any_o = |hits_i;

  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (hits_i[i]) idx_o = ($clog2(LANES))'(i);
  end

endmodule

// File: rtl/acf_filter.sv
module acf_filter
  import acf_pkg::*;
#(
  parameter int unsigned NUM_WORDS    = 128,
  parameter int unsigned NUM_IND_MASK = 32,
  localparam int unsigned NUM_FILT    = NUM_WORDS * 4,
  localparam int unsigned IDX_W       = $clog2(NUM_FILT),
  localparam int unsigned LANE_W      = $clog2(LANES),
  localparam int unsigned CNT_W       = IDX_W - LANE_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [28:0]                id_i,
  input  logic                       ide_i,
  input  logic                       rtr_i,
  input  logic [1:0]                 fmt_i,
  input  logic                       fifo_first_i,
  input  logic                       mb_hit_i,
  input  logic [NUM_WORDS*32-1:0]    filt_tab_i,
  input  logic [NUM_IND_MASK*32-1:0] ind_mask_i,
  input  logic [31:0]                glob_mask_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       fifo_hit_o,
  output logic [IDX_W-1:0]           hit_idx_o,
  output logic                       to_fifo_o,
  output logic                       to_mb_o
);

  localparam logic [CNT_W-1:0] LAST_EXT  = CNT_W'(NUM_WORDS / 8 - 1);
  localparam logic [CNT_W-1:0] LAST_STD  = CNT_W'(NUM_WORDS / 4 - 1);
  localparam logic [CNT_W-1:0] LAST_PART = CNT_W'(NUM_WORDS / 2 - 1);

  logic              busy_q, done_q, fifo_hit_q, to_fifo_q, to_mb_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q, last_cnt;
  acf_frame_t        frm_q;
  acf_fmt_e          fmt_q;
  logic              ff_q, mbh_q;
  logic [LANES-1:0]  hits;
  logic              any_hit;
  logic [LANE_W-1:0] lane;
  logic              finish;

  always_comb begin
    case (fmt_q)
      FMT_EXT: last_cnt = LAST_EXT;
      FMT_STD: last_cnt = LAST_STD;
      default: last_cnt = LAST_PART;
    endcase
  end

  acf_chunk #(
    .NUM_WORDS   (NUM_WORDS),
    .NUM_IND_MASK(NUM_IND_MASK),
    .CNT_W       (CNT_W)
  ) u_chunk (
    .tab_i      (filt_tab_i),
    .ind_mask_i (ind_mask_i),
    .glob_mask_i(glob_mask_i),
    .cnt_i      (cnt_q),
    .fmt_i      (fmt_q),
    .frm_i      (frm_q),
    .hits_o     (hits)
  );

  acf_prio8 u_prio (
    .hits_i(hits),
    .any_o (any_hit),
    .idx_o (lane)
  );

  assign finish = busy_q && (any_hit || cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      fifo_hit_q <= 1'b0;
      to_fifo_q  <= 1'b0;
      to_mb_q    <= 1'b0;
      idx_q      <= '0;
      cnt_q      <= '0;
      frm_q      <= '0;
      fmt_q      <= FMT_EXT;
      ff_q       <= 1'b0;
      mbh_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          frm_q  <= '{id: id_i, ide: ide_i, rtr: rtr_i};
          fmt_q  <= acf_fmt_e'(fmt_i);
          ff_q   <= fifo_first_i;
          mbh_q  <= mb_hit_i;
        end
      end else if (finish) begin
        busy_q     <= 1'b0;
        done_q     <= 1'b1;
        fifo_hit_q <= any_hit;
        idx_q      <= any_hit ? {cnt_q, lane} : '0;
        to_fifo_q  <= any_hit && (ff_q || !mbh_q);
        to_mb_q    <= mbh_q && (!ff_q || !any_hit);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign fifo_hit_o = fifo_hit_q;
  assign hit_idx_o  = idx_q;
  assign to_fifo_o  = to_fifo_q;
  assign to_mb_o    = to_mb_q;

  // R5: encoder picks a set lane with no lower lane set
  a_r5_lowest_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && any_hit |-> hits[lane] && ((hits & ((8'd1 << lane) - 8'd1)) == 8'd0));

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= last_cnt);

  a_r6_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_q) && !busy_q);

  a_r7_ignore_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(frm_q) && $stable(fmt_q));

  a_r8_one_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(to_fifo_o && to_mb_o));

  a_r8_fifo_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fifo_hit_o |-> !to_fifo_o);

  a_r10_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fifo_hit_o |-> hit_idx_o == '0);

endmodule

// File: tb/acf_filter_test.sv
module acf_filter_test;

  localparam int NW = 16;
  localparam int NM = 4;
  localparam int IW = $clog2(NW * 4);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [28:0] id = '0;
  logic ide = 1'b0, rtr = 1'b0, ff = 1'b0, mbh = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [31:0] tab [NW];
  logic [31:0] imask [NM];
  logic [31:0] gmask;
  logic [NW*32-1:0] tab_flat;
  logic [NM*32-1:0] imask_flat;
  logic busy, done, fhit, tofifo, tomb;
  logic [IW-1:0] hidx;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int w = 0; w < NW; w++) tab_flat[w*32 +: 32] = tab[w];
    for (int m = 0; m < NM; m++) imask_flat[m*32 +: 32] = imask[m];
  end

  acf_filter #(.NUM_WORDS(NW), .NUM_IND_MASK(NM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .id_i(id), .ide_i(ide),
    .rtr_i(rtr), .fmt_i(fmt), .fifo_first_i(ff), .mb_hit_i(mbh),
    .filt_tab_i(tab_flat), .ind_mask_i(imask_flat), .glob_mask_i(gmask),
    .busy_o(busy), .done_o(done), .fifo_hit_o(fhit), .hit_idx_o(hidx),
    .to_fifo_o(tofifo), .to_mb_o(tomb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ent_a(logic r, logic e, logic [28:0] i);
    return {r, e, 1'b0, i};
  endfunction

  function automatic logic [15:0] ent_b(logic r, logic e, logic [10:0] i);
    return {r, e, i, 3'b000};
  endfunction

  task automatic clear_tab();
    for (int w = 0; w < NW; w++) tab[w] = 32'hFFFF_FFFF;
    for (int m = 0; m < NM; m++) imask[m] = 32'hFFFF_FFFF;
    gmask = 32'hFFFF_FFFF;
  endtask

  // drive one search, count cycles from accepting edge to done
  task automatic search(input logic [28:0] i, input logic e, input logic r,
                        input logic [1:0] f, input logic pf, input logic pm,
                        output int lat);
    @(negedge clk);
    id = i; ide = e; rtr = r; fmt = f; ff = pf; mbh = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_res(input string tag, input int lat, input int exp_lat,
                            input int exp_hit, input int exp_idx);
    chk({tag, " latency"}, lat, exp_lat);
    chk({tag, " hit"}, int'(fhit), exp_hit);
    chk({tag, " index"}, int'(hidx), exp_idx);
  endtask

  task automatic t_reset();
    chk("R9 busy", int'(busy), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 hit", int'(fhit), 0);
    chk("R9 idx", int'(hidx), 0);
    chk("R9 to_fifo", int'(tofifo), 0);
    chk("R9 to_mb", int'(tomb), 0);
  endtask

  task automatic t_fmt_ext();
    int lat;
    clear_tab();
    tab[11] = ent_a(1'b0, 1'b1, 29'h1ABCDE12);
    tab[2]  = ent_a(1'b0, 1'b0, {11'h5A3, 18'h0});
    search(29'h1ABCDE12, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, lat);
    expect_res("R1 ext hit word11", lat, 2, 1, 11);
    search(29'h1ABCDE12, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, lat);
    expect_res("R1 R10 rtr mismatch", lat, 2, 0, 0);
    search(29'h5A3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, lat);
    expect_res("R1 std in ext table", lat, 1, 1, 2);
    search({11'h5A3, 18'h0}, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, lat);
    expect_res("R1 ide mismatch", lat, 2, 0, 0);
  endtask

  task automatic t_fmt_std();
    int lat;
    clear_tab();
    tab[5] = {ent_b(1'b0, 1'b1, 11'h2F1), 16'hFFFF};
    tab[9] = {16'hFFFF, ent_b(1'b0, 1'b0, 11'h123)};
    search({11'h2F1, 18'h31234}, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, lat);
    expect_res("R2 ext upper half", lat, 2, 1, 11);
    search(29'h123, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, lat);
    expect_res("R2 std lower half", lat, 3, 1, 18);
    search(29'h123, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, lat);
    expect_res("R2 R6 rtr mismatch full scan", lat, 4, 0, 0);
  endtask

  task automatic t_fmt_part();
    int lat;
    clear_tab();
    tab[13] = 32'hFFC5_FFFF;
    search(29'h62F, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, lat);
    expect_res("R3 std byte2 word13", lat, 7, 1, 54);
    search({8'hC5, 21'h0ABCD}, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, lat);
    expect_res("R3 ext rtr ignored", lat, 7, 1, 54);
    tab[3] = 32'hFFFF_C5FF;
    search(29'h62F, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, lat);
    expect_res("R5 lowest of 13 and 54", lat, 2, 1, 13);
    search(29'h000, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, lat);
    expect_res("R6 R10 partial no hit", lat, 8, 0, 0);
    @(negedge clk);
    chk("R6 done single cycle", int'(done), 0);
  endtask

  task automatic t_masks();
    int lat;
    clear_tab();
    tab[1] = ent_a(1'b0, 1'b1, 29'h100000A0);
    imask[1] = 32'hFFFF_FF0F;
    search(29'h100000B0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, lat);
    expect_res("R4 individual mask", lat, 1, 1, 1);
    tab[1] = 32'hFFFF_FFFF;
    tab[5] = ent_a(1'b0, 1'b1, 29'h100000A0);
    search(29'h100000B0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, lat);
    expect_res("R4 global mask strict", lat, 2, 0, 0);
    gmask = 32'hFFFF_FF0F;
    search(29'h100000B0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, lat);
    expect_res("R4 global mask relaxed", lat, 1, 1, 5);
  endtask

  task automatic t_route();
    int lat;
    clear_tab();
    tab[0] = ent_a(1'b0, 1'b1, 29'h5);
    search(29'h5, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, lat);
    chk("R8 fifo first both", int'({tofifo, tomb}), 2);
    search(29'h5, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, lat);
    chk("R8 mailbox first both", int'({tofifo, tomb}), 1);
    chk("R8 hit kept when mailbox wins", int'(fhit), 1);
    search(29'h5, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, lat);
    chk("R8 fifo only", int'({tofifo, tomb}), 2);
    search(29'h6, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, lat);
    chk("R8 mailbox only", int'({tofifo, tomb}), 1);
    search(29'h6, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, lat);
    chk("R8 neither", int'({tofifo, tomb}), 0);
  endtask

  task automatic t_busy_ignore();
    int lat;
    clear_tab();
    tab[0] = 32'hFFFF_FF3C;
    @(negedge clk);
    id = 29'h000; ide = 1'b0; rtr = 1'b0; fmt = 2'd2; ff = 1'b1; mbh = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk("R7 busy after start", int'(busy), 1);
    repeat (2) begin @(negedge clk); lat++; end
    id = 29'h1E0; fmt = 2'd0; mbh = 1'b1; start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    expect_res("R7 R11 restart ignored", lat, 8, 0, 0);
    chk("R11 mailbox flag held", int'(tomb), 0);
    chk("R7 busy clear at done", int'(busy), 0);
    search(29'h1E0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, lat);
    expect_res("R11 same id accepted", lat, 1, 1, 0);
  endtask

  initial begin
    clear_tab();
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_fmt_ext();
    t_fmt_std();
    t_fmt_part();
    t_masks();
    t_route();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule